// File: doc/BRIEF.md
# Lockable Watchdog Timer with Reset-Cause Latch

The block counts ticks and fires when software stops servicing it. Software writes an 8-bit control byte. That byte arms the timer, picks one of four time-out lengths, and chooses where the ticks come from: every system clock, or a slow real-time strobe that is already synchronous to the system clock. Software keeps the timer quiet by writing a two-byte key to a separate restart port. If the count reaches its limit, the block does one of two things, depending on the action bit. It either pulses a CPU reset request or pulses a nonmaskable interrupt request.

The arm bit is one-way. Once set it stays set until a full chip reset. A cause latch remembers that the watchdog fired. It is set on every expiry, whatever the action. A watchdog-sourced reset does not clear it. Only a full reset clears it, so software can read the control byte after a reset or an interrupt and learn whether the watchdog caused it. The reset request pulse is meant to be routed back into the block's watchdog-reset input, together with the CPU's own reset.

Top module: `wdog_top`

## Requirements
- R1: Control bit 7 (arm) sets when a control write carries a 1 there. A control write with 0 in bit 7 leaves it set. Only `rst` clears it, and `wd_rst` does not.
- R2: Control bit 6 selects the expiry action. With 0, `rst_req` pulses high for one cycle. With 1, `nmi_req` pulses high for one cycle. The two pulses are never high together.
- R3: `ctl_rdata` reads as {arm, action, cause, clock select[1:0], 0, length[1:0]}, from bit 7 down to bit 0. Bit 2 always reads 0, and bit 5 cannot be written. After `rst` the byte reads 00h.
- R4: The cause bit (bit 5) reads 1 from the cycle after any expiry pulse, in either action mode.
- R5: Once set, the cause bit stays set through `wd_rst` and through control writes. Only `rst` clears it, and an assertion of `wd_rst` alone sets it. `wd_rst` keeps the control bits and restarts the count.
- R6: Clock select 00 advances the count on every clock cycle. Clock select 01 advances it only in cycles where `rtc_tick` is high.
- R7: Clock select 10 or 11 freezes the count, so no expiry occurs.
- R8: Length code n in bits 1:0 gives a limit of 2^PERn_LOG2 ticks. The expiry pulse appears in the cycle after the edge that takes the limit-th tick after the last restart.
- R9: A restart-port write of A5h followed by 5Ah on the next restart-port write restarts the count from zero. Any other value written between the two cancels the key.
- R10: Every control write restarts the count from zero.
- R11: In interrupt mode the counter wraps after each expiry and keeps going, so `nmi_req` pulses once every limit ticks.
- R12: While the arm bit is 0, neither request ever pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Full chip reset, synchronous, active high |
| wd_rst | input | 1 | Reset that originates from this watchdog, synchronous, active high |
| rtc_tick | input | 1 | One-cycle slow-tick strobe, synchronous to `clk` |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte read value |
| kick_we | input | 1 | Restart port write strobe |
| kick_wdata | input | 8 | Restart port write data |
| rst_req | output | 1 | One-cycle CPU reset request |
| nmi_req | output | 1 | One-cycle nonmaskable interrupt request |

## Verification
The bench builds the block with length exponents 6, 5, 4 and 3, which gives limits of 64, 32, 16 and 8 ticks. At those sizes each limit can be measured exactly. Repeated interrupt-mode expiries, the real-time-strobe path and the restart key all complete within a few hundred cycles. The reset request is looped back into `wd_rst`. This lets the bench check that the cause bit and the arm bit both survive the watchdog's own reset.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        CK_SYS  = 2'b00,
        CK_RTC  = 2'b01,
        CK_RSVA = 2'b10,
        CK_RSVB = 2'b11
    } clk_sel_e;

    typedef struct packed {
        logic     arm;
        logic     nmi_mode;
        clk_sel_e csel;
        logic [1:0] len;
    } wd_cfg_t;

    localparam logic [7:0] KEY_ARM  = 8'hA5;
    localparam logic [7:0] KEY_FIRE = 8'h5A;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic logic [7:0] pack_ctl(input wd_cfg_t c, input logic cause);
        return {c.arm, c.nmi_mode, cause, c.csel, 1'b0, c.len};
    endfunction

    function automatic wd_cfg_t unpack_ctl(input wd_cfg_t old, input logic [7:0] d);
        wd_cfg_t n;
        n.arm      = old.arm | d[7];
        n.nmi_mode = d[6];
        n.csel     = clk_sel_e'(d[4:3]);
        n.len      = d[1:0];
        return n;
    endfunction

endpackage

// File: rtl/wdog_ctl.sv
module wdog_ctl
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wd_rst,
    input  logic       we,
    input  logic [7:0] wdata,
    input  logic       expire,
    output wd_cfg_t    cfg,
    output logic       cause
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= '0;
            cause <= 1'b0;
        end else begin
            if (we) begin
                cfg <= unpack_ctl(cfg, wdata);
            end
            if (expire || wd_rst) begin
                cause <= 1'b1;
            end
        end
    end

    // R1: arm bit is one-way outside a full reset
    a_r1_arm_sticky: assert property (@(posedge clk) disable iff (rst)
        cfg.arm |=> cfg.arm);

    // R5: cause bit is cleared only by full reset
    a_r5_cause_holds: assert property (@(posedge clk) disable iff (rst)
        cause |=> cause);

    // R4: every expiry marks the cause bit
    a_r4_cause_on_expire: assert property (@(posedge clk) disable iff (rst)
        expire |=> cause);

endmodule

// File: rtl/wdog_kick.sv
module wdog_kick
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       we,
    input  logic [7:0] wdata,
    output logic       kick
);

    logic armed;

    assign kick = we && (wdata == KEY_FIRE) && armed;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            armed <= 1'b0;
        end else if (we) begin
            armed <= (wdata == KEY_ARM);
        end
    end

    // R9: a completed key consumes the arming
    a_r9_key_consumed: assert property (@(posedge clk) disable iff (rst)
        kick |=> !armed);

endmodule

// File: rtl/wdog_count.sv
module wdog_count
    import wdog_pkg::*;
#(
    parameter int PER0_LOG2 = 27,
    parameter int PER1_LOG2 = 25,
    parameter int PER2_LOG2 = 22,
    parameter int PER3_LOG2 = 18
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       arm,
    input  clk_sel_e   csel,
    input  logic [1:0] len,
    input  logic       rtc_tick,
    output logic       expire
);

    localparam int CNT_W = max4(PER0_LOG2, PER1_LOG2, PER2_LOG2, PER3_LOG2);
    localparam int LOG2_TAB [4] = '{PER0_LOG2, PER1_LOG2, PER2_LOG2, PER3_LOG2};

    logic [CNT_W-1:0] lim_tab [4];
    logic [CNT_W-1:0] cnt;
    logic             tick;

    for (genvar g = 0; g < 4; g++) begin : g_lim
        assign lim_tab[g] = CNT_W'((64'd1 << LOG2_TAB[g]) - 64'd1);
    end

    always_comb begin
        unique case (csel)
            CK_SYS:  tick = 1'b1;
            CK_RTC:  tick = rtc_tick;
            default: tick = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt    <= '0;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (arm && tick) begin
                if (cnt == lim_tab[len]) begin
                    cnt    <= '0;
                    expire <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R7: reserved clock selects freeze the count
    a_r7_reserved_freeze: assert property (@(posedge clk) disable iff (rst)
        (!clr && (csel == CK_RSVA || csel == CK_RSVB)) |=> $stable(cnt));

    // R12: no expiry while disarmed
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !arm |=> !expire);

    // R2: expiry is a single-cycle pulse
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        expire |=> !expire);

endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int PER0_LOG2 = 27,
    parameter int PER1_LOG2 = 25,
    parameter int PER2_LOG2 = 22,
    parameter int PER3_LOG2 = 18
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wd_rst,
    input  logic       rtc_tick,
    input  logic       ctl_we,
    input  logic [7:0] ctl_wdata,
    output logic [7:0] ctl_rdata,
    input  logic       kick_we,
    input  logic [7:0] kick_wdata,
    output logic       rst_req,
    output logic       nmi_req
);

    wd_cfg_t cfg;
    logic    cause;
    logic    expire;
    logic    kick;
    logic    restart;

    assign restart = ctl_we | kick | wd_rst;

    wdog_ctl u_ctl (
        .clk    (clk),
        .rst    (rst),
        .wd_rst (wd_rst),
        .we     (ctl_we),
        .wdata  (ctl_wdata),
        .expire (expire),
        .cfg    (cfg),
        .cause  (cause)
    );

    wdog_kick u_kick (
        .clk   (clk),
        .rst   (rst),
        .clr   (wd_rst),
        .we    (kick_we),
        .wdata (kick_wdata),
        .kick  (kick)
    );

    wdog_count #(
        .PER0_LOG2 (PER0_LOG2),
        .PER1_LOG2 (PER1_LOG2),
        .PER2_LOG2 (PER2_LOG2),
        .PER3_LOG2 (PER3_LOG2)
    ) u_count (
        .clk      (clk),
        .rst      (rst),
        .clr      (restart),
        .arm      (cfg.arm),
        .csel     (cfg.csel),
        .len      (cfg.len),
        .rtc_tick (rtc_tick),
        .expire   (expire)
    );

    assign ctl_rdata = pack_ctl(cfg, cause);
    assign rst_req   = expire & ~cfg.nmi_mode;
    assign nmi_req   = expire &  cfg.nmi_mode;

    // R2: the two requests are mutually exclusive
    a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rst_req && nmi_req));

    // R3: bit 2 of the control readback is always zero
    a_r3_bit2_zero: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[2] == 1'b0);

endmodule

// File: tb/wdog_top_tb_top.sv
module wdog_top_tb_top;

    localparam int L0 = 6;
    localparam int L1 = 5;
    localparam int L2 = 4;
    localparam int L3 = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rtc_tick = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       kick_we = 1'b0;
    logic [7:0] kick_wdata = '0;
    logic [7:0] ctl_rdata;
    logic       rst_req;
    logic       nmi_req;
    logic       wd_rst;

    int checks = 0;
    int errors = 0;

    assign wd_rst = rst_req;

    always #2 clk = ~clk;

    wdog_top #(
        .PER0_LOG2 (L0),
        .PER1_LOG2 (L1),
        .PER2_LOG2 (L2),
        .PER3_LOG2 (L3)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .wd_rst     (wd_rst),
        .rtc_tick   (rtc_tick),
        .ctl_we     (ctl_we),
        .ctl_wdata  (ctl_wdata),
        .ctl_rdata  (ctl_rdata),
        .kick_we    (kick_we),
        .kick_wdata (kick_wdata),
        .rst_req    (rst_req),
        .nmi_req    (nmi_req)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic full_reset();
        rst = 1'b1;
        wait_neg(2);
        rst = 1'b0;
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_we = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wr_kick(input logic [7:0] v);
        kick_we = 1'b1;
        kick_wdata = v;
        @(negedge clk);
        kick_we = 1'b0;
    endtask

    // Checks quiet for n-1 cycles, then a pulse on the chosen line, then quiet.
    task automatic expect_pulse(input string req, input int n, input bit nmi);
        int seen;
        seen = 0;
        for (int i = 0; i < n - 1; i++) begin
            @(negedge clk);
            if (rst_req || nmi_req) seen++;
        end
        check({req, " early pulse"}, seen, 0);
        @(negedge clk);
        check({req, " nmi_req at limit"}, nmi_req, nmi);
        check({req, " rst_req at limit"}, rst_req, !nmi);
        @(negedge clk);
        check({req, " pulse one cycle"}, rst_req | nmi_req, 0);
    endtask

    task automatic t_reset_state();
        full_reset();
        check("R3 reset readback", ctl_rdata, 8'h00);
        check("R12 reset quiet", rst_req | nmi_req, 0);
    endtask

    task automatic t_disarmed();
        int seen;
        full_reset();
        wr_ctl(8'h7F);
        check("R3 readback mask", ctl_rdata, 8'h5B);
        wr_ctl(8'h43);
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (rst_req || nmi_req) seen++;
        end
        check("R12 disarmed no pulse", seen, 0);
    endtask

    task automatic t_reset_mode();
        full_reset();
        wr_ctl(8'h83);
        expect_pulse("R2 R8 reset mode", 1 << L3, 1'b0);
        check("R4 R5 cause after wd reset", ctl_rdata, 8'hA3);
        wr_ctl(8'h03);
        check("R1 arm sticky", ctl_rdata, 8'hA3);
        full_reset();
        check("R1 R5 full reset clears", ctl_rdata, 8'h00);
    endtask

    task automatic t_nmi_mode();
        full_reset();
        wr_ctl(8'hC2);
        expect_pulse("R2 nmi first", 1 << L2, 1'b1);
        check("R4 cause in nmi mode", ctl_rdata[5], 1);
        expect_pulse("R11 nmi wrap", (1 << L2) - 1, 1'b1);
    endtask

    task automatic measure(input string req, input logic [1:0] code, input int exp);
        int n;
        full_reset();
        wr_ctl({6'b110000, code});
        n = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            n++;
            if (nmi_req) break;
        end
        check(req, n, exp);
    endtask

    task automatic t_kick();
        full_reset();
        wr_ctl(8'hC3);
        wait_neg(3);
        wr_kick(8'hA5);
        wr_kick(8'h5A);
        expect_pulse("R9 key restarts", 1 << L3, 1'b1);
        full_reset();
        wr_ctl(8'hC3);
        wait_neg(1);
        wr_kick(8'hA5);
        wr_kick(8'h33);
        wr_kick(8'h5A);
        expect_pulse("R9 broken key ignored", 4, 1'b1);
    endtask

    task automatic t_ctl_restart();
        full_reset();
        wr_ctl(8'hC3);
        wait_neg(6);
        wr_ctl(8'hC3);
        expect_pulse("R10 ctl write restarts", 1 << L3, 1'b1);
    endtask

    task automatic t_rtc();
        int seen;
        full_reset();
        wr_ctl(8'hCB);
        seen = 0;
        for (int t = 0; t < (1 << L3); t++) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                if (nmi_req) seen++;
            end
            rtc_tick = 1'b1;
            @(negedge clk);
            rtc_tick = 1'b0;
            if (t < (1 << L3) - 1 && nmi_req) seen++;
        end
        check("R6 no pulse before last tick", seen, 0);
        check("R6 pulse on last tick", nmi_req, 1);
        @(negedge clk);
        check("R6 pulse ends", nmi_req, 0);
    endtask

    task automatic t_reserved();
        int seen;
        full_reset();
        wr_ctl(8'hD3);
        seen = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (rst_req || nmi_req) seen++;
        end
        check("R7 reserved select frozen", seen, 0);
        wr_ctl(8'hC3);
        expect_pulse("R7 resume after select", 1 << L3, 1'b1);
    endtask

    initial begin
        wait_neg(1);
        t_reset_state();
        t_disarmed();
        t_reset_mode();
        t_nmi_mode();
        measure("R8 length code 0", 2'd0, 1 << L0);
        measure("R8 length code 1", 2'd1, 1 << L1);
        t_kick();
        t_ctl_restart();
        t_rtc();
        t_reserved();
        finish_run();
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

endmodule